// File: doc/BRIEF.md
# Multi-Mode Sample-to-Lane Mapper

This block collects 12-bit samples from a bank of 32 ADC channels and spreads them over a set of parallel lane words that feed a constant-rate serial link. Each channel writes into its own 8-entry, 12-bit elastic buffer. A sequencer then visits the channels in a fixed rotation and places one sample per lane per clock into a 16-bit lane word. A two-bit mode setting chooses how many channels share a lane: 2, 4 or 8. The number of active lanes follows that choice (16, 8 or 4 lanes), so each lane always carries one word per cycle whatever the ADC sampling rate. Lanes left over in the narrower modes stay silent.

The sequencer is a two-state machine. `ST_HOLD` is entered by reset. Lane outputs stay idle in this state while the buffers fill. Transition `T_START` moves it to `ST_STREAM` once every channel buffer holds at least one sample. `ST_STREAM` has a single self-transition, `T_KEEP`, and leaves only through reset. In `ST_STREAM` a slot counter steps through 0 to N−1, where N is the number of channels per lane. In slot s, lane k emits channel k·N+s and pops that channel's buffer. A channel whose buffer is empty when its slot arrives produces a zero word and raises a sticky underflow flag.

The mode is captured only while reset is held, so a new mode always starts with empty buffers and a fresh rotation.

Top module: `ch_lane_mapper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `lane_valid`, `lane_data` and `underflow` become all zero and the sequencer returns to `ST_HOLD`.
- R2: `mode_sel` code 0 gives 2 channels per lane on 16 lanes. Code 1 gives 4 channels per lane on 8 lanes. Code 2 gives 8 channels per lane on 4 lanes. Code 3 behaves exactly like code 0.
- R3: `mode_sel` is sampled only on edges where `rst_n` is low. Changing it while out of reset has no effect on lane count, sharing or order.
- R4: After reset, all `lane_valid` bits stay low until every channel buffer holds at least one sample (`T_START`). From then on, `lane_valid` shows the active lanes on every cycle until the next reset.
- R5: With N channels per lane, lane k carries channels k·N, k·N+1, …, k·N+N−1 in ascending order, one per cycle, and repeats this rotation for as long as it streams.
- R6: Each lane word is 16 bits. The 12-bit sample sits in bits [15:4] and bits [3:0] are zero.
- R7: Lanes with index k ≥ 32/N keep `lane_valid[k]` low and drive an all-zero word.
- R8: If a channel's buffer is empty when its slot comes up, its lane still shows valid but the word is zero, and `underflow[c]` sets and stays set until reset. A channel that always has data never sets its flag.
- R9: Each channel buffer holds 8 samples in arrival order. A write that arrives while the buffer is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock; all logic is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also loads the mode |
| mode_sel | input | 2 | Sharing mode code (0: 2 per lane, 1: 4, 2: 8, 3: as 0) |
| smp_valid | input | 32 | Per-channel write strobe |
| smp_data | input | 384 | Per-channel 12-bit samples; channel c at bits [12c+11:12c] |
| lane_data | output | 256 | Lane words; lane k at bits [16k+15:16k] |
| lane_valid | output | 16 | Per-lane valid flag |
| underflow | output | 32 | Sticky per-channel empty-slot flag |

## Verification
Each sample is tagged with its channel number and a sequence count, so a captured lane stream shows at once whether it has the wrong channel, the wrong round or a missing container pad. The mapping is run in all four mode codes with shallow and full buffer fills. This separates the three sharing ratios and confirms that code 3 aliases the first mode. One run changes the mode pin mid-stream, and the lane pattern must not move. Another run withholds the top channel while overfilling the rest. This shows that lanes stay idle until every buffer has data and that excess writes vanish. Draining every buffer afterwards makes zero words appear exactly after the last real round and sets every underflow flag.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    // Sharing ratio expressed as a left shift of the minimum ratio.
    typedef enum logic [1:0] {
        MODE_FULL    = 2'd0,
        MODE_HALF    = 2'd1,
        MODE_QUARTER = 2'd2
    } lane_mode_e;

    typedef enum logic {
        ST_HOLD   = 1'b0,
        ST_STREAM = 1'b1
    } map_state_e;

    function automatic lane_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd1:    return MODE_HALF;
            2'd2:    return MODE_QUARTER;
            default: return MODE_FULL;   // code 3 aliases code 0
        endcase
    endfunction

endpackage

// File: rtl/mapper_chan_fifo.sv
module mapper_chan_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign empty   = (count == '0);
    assign do_wr   = wr_en && (count != CW'(DEPTH));
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/mapper_slot_fsm.sv
module mapper_slot_fsm
    import mapper_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              all_ready,
    input  logic [SLOT_W-1:0] slot_last,
    output logic              streaming,
    output logic [SLOT_W-1:0] slot
);
    map_state_e state, state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nxt;
    end

    // transitions: T_START (HOLD->STREAM), T_KEEP (STREAM->STREAM)
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD:   state_nxt = all_ready ? ST_STREAM : ST_HOLD;
            ST_STREAM: state_nxt = ST_STREAM;
        endcase
    end

    // outputs
    always_comb begin
        streaming = (state == ST_STREAM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !streaming) slot <= '0;
        else if (slot == slot_last) slot <= '0;
        else slot <= slot + 1'b1;
    end

endmodule

// File: rtl/ch_lane_mapper.sv
module ch_lane_mapper
    import mapper_pkg::*;
#(
    parameter  int NUM_CH     = 32,
    parameter  int SAMPLE_W   = 12,
    parameter  int WORD_W     = 16,
    parameter  int FIFO_DEPTH = 8,
    parameter  int MIN_SHARE  = 2,
    parameter  int MAX_SHARE  = 8,
    localparam int MAX_LANES  = NUM_CH / MIN_SHARE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   mode_sel,
    input  logic [NUM_CH-1:0]            smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0]   smp_data,
    output logic [MAX_LANES*WORD_W-1:0]  lane_data,
    output logic [MAX_LANES-1:0]         lane_valid,
    output logic [NUM_CH-1:0]            underflow
);
    localparam int SLOT_W   = $clog2(MAX_SHARE);
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int PAD_W    = WORD_W - SAMPLE_W;
    localparam int BASE_LOG = $clog2(MIN_SHARE);

    lane_mode_e          mode_q;
    logic [SLOT_W-1:0]   slot_last;
    logic [SLOT_W-1:0]   slot;
    logic                streaming;
    int                  share_log;
    int                  act_lanes;
    logic [NUM_CH-1:0]   empty_v;
    logic [NUM_CH-1:0]   rd_en;
    logic [SAMPLE_W-1:0] head [NUM_CH];

    // mode is loaded only while reset is asserted
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= decode_mode(mode_sel);
    end

    always_comb begin
        share_log = BASE_LOG + int'(mode_q);
        act_lanes = MAX_LANES >> int'(mode_q);
        slot_last = SLOT_W'((MIN_SHARE << int'(mode_q)) - 1);
    end

    mapper_slot_fsm #(.SLOT_W(SLOT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_ready (&(~empty_v)),
        .slot_last (slot_last),
        .streaming (streaming),
        .slot      (slot)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic uf_q;

        // channel c is visited when its position within its lane matches the slot
        assign rd_en[c] = streaming && ((SLOT_W'(c) & slot_last) == slot);

        mapper_chan_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (smp_valid[c]),
            .wr_data (smp_data[c*SAMPLE_W +: SAMPLE_W]),
            .rd_en   (rd_en[c]),
            .rd_data (head[c]),
            .empty   (empty_v[c])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)                    uf_q <= 1'b0;
            else if (rd_en[c] && empty_v[c]) uf_q <= 1'b1;
        end

        assign underflow[c] = uf_q;
    end

    for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
        logic [CH_W-1:0]   pick;
        logic              lane_on;
        logic [WORD_W-1:0] word_q;
        logic              valid_q;

        always_comb begin
            pick    = CH_W'((k << share_log) + int'(slot));
            lane_on = streaming && (k < act_lanes);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q  <= '0;
                valid_q <= 1'b0;
            end else begin
                valid_q <= lane_on;
                word_q  <= (lane_on && !empty_v[pick]) ? {head[pick], {PAD_W{1'b0}}} : '0;
            end
        end

        assign lane_data[k*WORD_W +: WORD_W] = word_q;
        assign lane_valid[k]                 = valid_q;
    end

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
    parameter int NUM_CH    = 32,
    parameter int MAX_LANES = 16,
    parameter int WORD_W    = 16,
    parameter int PAD_W     = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [MAX_LANES*WORD_W-1:0] lane_data,
    input logic [MAX_LANES-1:0]        lane_valid,
    input logic [NUM_CH-1:0]           underflow
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (lane_valid == '0 && underflow == '0 && lane_data == '0)); // R1

    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lane_valid) == 0 || $countones(lane_valid) == MAX_LANES ||
         $countones(lane_valid) == MAX_LANES / 2 || $countones(lane_valid) == MAX_LANES / 4)); // R2

    AST_LOW_LANES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(MAX_LANES'(lane_valid + 1'b1))); // R7

    AST_PATTERN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid != '0) |=> $stable(lane_valid)); // R3

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow != '0) |=> ((underflow & $past(underflow)) == $past(underflow))); // R8

    for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane_chk
        AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            lane_data[k*WORD_W +: PAD_W] == '0); // R6

        AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_valid[k] |-> (lane_data[k*WORD_W +: WORD_W] == '0)); // R7
    end

endmodule

bind ch_lane_mapper mapper_checker #(
    .NUM_CH    (NUM_CH),
    .MAX_LANES (MAX_LANES),
    .WORD_W    (WORD_W),
    .PAD_W     (PAD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_data  (lane_data),
    .lane_valid (lane_valid),
    .underflow  (underflow)
);

// File: tb/tb_ch_lane_mapper.sv
module tb_ch_lane_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 32;
    localparam int NL    = 16;
    localparam int CAPN  = 96;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode_sel = 2'd0;
    logic [NCH-1:0]  smp_valid = '0;
    logic [NCH*12-1:0] smp_data = '0;
    logic [NL*16-1:0]  lane_data;
    logic [NL-1:0]     lane_valid;
    logic [NCH-1:0]    underflow;

    int checks = 0;
    int failures = 0;

    ch_lane_mapper dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .lane_data(lane_data), .lane_valid(lane_valid), .underflow(underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // capture of lane streams, sampled at the falling edge
    logic [15:0] cap [NL][CAPN];
    int          cnt [NL];
    bit          mon_en = 1'b0;
    bit          bad_unused;
    int          act_exp = NL;

    always @(negedge clk) begin
        for (int k = 0; k < NL; k++) begin
            if (!mon_en) begin
                cnt[k] = 0;
            end else begin
                if (lane_valid[k]) begin
                    if (cnt[k] < CAPN) cap[k][cnt[k]] = lane_data[k*16 +: 16];
                    cnt[k] = cnt[k] + 1;
                end
                if (k >= act_exp && (lane_valid[k] || lane_data[k*16 +: 16] != 16'h0))
                    bad_unused = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [15:0] exp_word(input int ch, input int seq);
        return {ch[4:0], seq[6:0], 4'b0000};
    endfunction

    task automatic drive_round(input bit low_ch, input bit top_ch, input int seq);
        for (int c = 0; c < NCH; c++) begin
            smp_valid[c] = (c == NCH-1) ? top_ch : low_ch;
            smp_data[c*12 +: 12] = {c[4:0], seq[6:0]};
        end
        step();
        smp_valid = '0;
    endtask

    task automatic do_reset(input logic [1:0] code, input int n);
        mon_en   = 1'b0;
        rst_n    = 1'b0;
        mode_sel = code;
        smp_valid = '0;
        repeat (3) step();
        rst_n = 1'b1;
        act_exp = NCH / n;
        bad_unused = 1'b0;
        step();
        check(lane_valid == '0 && lane_data == '0 && underflow == '0, "R1", "reset state",
              {lane_valid, underflow, 16'h0}, 64'h0);
        mon_en = 1'b1;
    endtask

    // One scenario: mode code, sharing n, rounds written, hold variant, mode poke
    task automatic run_case(input logic [1:0] code, input int n, input int rounds,
                            input bit hold_var, input bit poke);
        int depth;
        int bad;
        int padbad;
        int lanes_seen;
        int t;
        do_reset(code, n);
        if (hold_var) begin
            // R4/R9: fill all but the top channel past capacity
            for (int s = 0; s < 10; s++) drive_round(1'b1, 1'b0, s);
            check(lane_valid == '0 && cnt[0] == 0, "R4", "idle before all channels ready",
                  {48'h0, lane_valid}, 64'h0);
            for (int s = 0; s < 8; s++) drive_round(1'b0, 1'b1, s);
            depth = 8;
        end else begin
            for (int s = 0; s < rounds; s++) begin
                if (poke && s == 1) mode_sel = 2'd2;
                drive_round(1'b1, 1'b1, s);
            end
            depth = rounds;
        end
        t = 0;
        while (cnt[0] < depth*n && t < 500) begin
            step();
            t++;
        end
        check(cnt[0] >= depth*n, "R4", "stream started", cnt[0], depth*n);
        check(underflow == '0, "R8", "no underflow while fed", underflow, 64'h0);
        repeat (n + 2) step();
        check(underflow == '1, "R8", "all flags after drain", underflow, {32'h0, 32'hFFFF_FFFF});
        bad = 0;
        padbad = 0;
        lanes_seen = 0;
        for (int k = 0; k < NL; k++) begin
            if (cnt[k] > 0) lanes_seen++;
            if (k < act_exp) begin
                for (int i = 0; i < depth*n; i++) begin
                    if (cap[k][i] != exp_word(k*n + (i % n), i / n)) bad++;
                    if (cap[k][i][3:0] != 4'h0) padbad++;
                end
            end
        end
        check(bad == 0, "R5", "lane channel order", bad, 0);
        check(padbad == 0, "R6", "container pad bits", padbad, 0);
        check(lanes_seen == act_exp, poke ? "R2 R3" : "R2", "active lane count", lanes_seen, act_exp);
        check(!bad_unused, "R7", "unused lanes silent", bad_unused, 0);
        bad = 0;
        for (int k = 0; k < act_exp; k++)
            if (cnt[k] <= depth*n || cap[k][depth*n] != 16'h0) bad++;
        check(bad == 0, hold_var ? "R8 R9" : "R8", "zero word after last sample", bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        run_case(2'd0, 2, 6, 1'b0, 1'b0);  // R2 full sharing
        run_case(2'd1, 4, 5, 1'b0, 1'b1);  // R2 R3 half sharing, mode pin moved
        run_case(2'd2, 8, 8, 1'b1, 1'b0);  // R4 R9 quarter, hold and overfill
        run_case(2'd3, 2, 3, 1'b0, 1'b0);  // R2 alias code
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule